// File: doc/BRIEF.md
# Bit-Serial Register Access Slave

This block terminates a slow, pin-level serial link through which a host reads and writes a small bank of 16-bit registers. The host drives four lines into the block: an active-low clear, a strobe that serves as the link clock, serial data toward the device, and an enable. The block drives one serial data line back. All four host lines are brought into the system clock domain through two-flop synchronisers. Strobe edges are then found on the synchronised copy, so the host may toggle the pins at any pace slower than a few system clocks.

A transaction begins with a clear pulse. The host then shifts in an 8-bit command, and one of two things follows. In a write, the host sends 16 data bits. In a read, the block returns 16 bits. The register bank holds a hardwired identification word and a firmware-version word, and both are read-only. It also holds a parameterised number of function-enable, pin-enable and pin-direction words, which can be read and written.

Top module: `bsr_slave`

## Requirements
- R1: Taking the clear input low and then back high abandons any partial frame. The next strobe rising edge is counted as the first command bit, and a write interrupted this way leaves every register unchanged.
- R2: The command is the first 8 bits shifted in, MSB first. Bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the register address. The host sets the data line while the strobe is low, and the block samples it on the strobe rising edge.
- R3: In a write, 16 data bits follow the command MSB first, each sampled on a strobe rising edge. The addressed register takes the value only once the 16th bit is sampled.
- R4: In a read, bit 15 of the addressed register is on the data-out line after the first strobe rise and fall that follow the command. Each further rise-and-fall pair presents the next lower bit, down to bit 0.
- R5: Address 0x00 is the identification word and reads 0x0001, with the manufacturer code 0x01 in bits 7:0.
- R6: Address 0x01 is the firmware word, laid out as build in 15:12, major in 11:8 (always 0), minor in 7:4 and patch in 3:0. With the default parameters (build 2, minor 3, patch 4) it reads 0x2034.
- R7: Writes to addresses 0x00 and 0x01 are discarded.
- R8: Function-enable words are at 0x08 and 0x09, pin-enable words at 0x10 to 0x12, and pin-direction words at 0x18 to 0x1A. All of them reset to 0 and read back the last value written.
- R9: Reads of any other address return 0, and writes to it change no register.
- R10: While the enable input is low, data-out is held low and strobe edges are ignored, so a complete write frame sent during that time has no effect.
- R11: Strobe rising edges after the 24th bit of a frame, up to the next clear, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Link enable from host |
| clr_ni | input | 1 | Transaction clear, active low |
| stb_i | input | 1 | Serial strobe from host |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |

## Verification
The clear line and the strobe pass through separate synchronisers. A clear falling and the final write rising edge can therefore land in the same system clock cycle. The bench provokes this by lowering clear and raising strobe in the same step at the 24th data bit. It expects clear to win, so a later read must return the value the register held before. A second case drops enable in the middle of a read while data-out is high. The bench expects the line to be low before the next strobe edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int CMD_W  = ADDR_W + 1;
  localparam int FRAME_LEN = CMD_W + DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bsr_frame.sv
module bsr_frame
  import bsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  clr_ni,
  input  logic  stb_i,
  input  logic  din_i,
  input  data_t rd_data_i,
  output addr_t addr_o,
  output logic  wr_o,
  output data_t wr_data_o,
  output logic  dout_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic             stb_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] cmd_q;
  logic             rd_q;
  logic             wr_q;
  data_t            sh_q;
  logic             rise;

  assign rise = stb_i & ~stb_d & en_i & clr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_d <= 1'b0;
      cnt_q <= '0;
      cmd_q <= '0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      sh_q  <= '0;
    end else begin
      stb_d <= stb_i;
      wr_q  <= 1'b0;
      if (!clr_ni) begin
        cnt_q <= '0;
        cmd_q <= '0;
        rd_q  <= 1'b0;
        sh_q  <= '0;
      end else if (rise) begin
        if (cnt_q < CNT_W'(CMD_W)) begin
          cmd_q <= {cmd_q[CMD_W-2:0], din_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(CMD_W - 1)) rd_q <= cmd_q[CMD_W-2];
        end else if (cnt_q < CNT_W'(FRAME_LEN)) begin
          cnt_q <= cnt_q + 1'b1;
          if (rd_q) begin
            // first data edge loads, later edges advance
            if (cnt_q == CNT_W'(CMD_W)) sh_q <= rd_data_i;
            else                        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
          end else begin
            sh_q <= {sh_q[DATA_W-2:0], din_i};
            if (cnt_q == CNT_W'(FRAME_LEN - 1)) wr_q <= 1'b1;
          end
        end
      end
    end
  end

  assign addr_o    = cmd_q[ADDR_W-1:0];
  assign wr_o      = wr_q;
  assign wr_data_o = sh_q;
  assign dout_o    = rd_q & (cnt_q > CNT_W'(CMD_W)) & sh_q[DATA_W-1];

  // R1
  clr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (cnt_q == '0) && !rd_q);

  // R11
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_LEN));

  // R3
  wr_only_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !rd_q && (cnt_q == CNT_W'(FRAME_LEN)));

  // R2
  cmd_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && cnt_q < CNT_W'(CMD_W)) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/bsr_regbank.sv
module bsr_regbank
  import bsr_pkg::*;
#(
  parameter int          N_FUNC   = 2,
  parameter int          N_PIN    = 3,
  parameter int          FUNC_BASE = 8,
  parameter int          PEN_BASE  = 16,
  parameter int          PDIR_BASE = 24,
  parameter logic [7:0]  MFG_CODE  = 8'h01,
  parameter logic [3:0]  FW_BUILD  = 4'h2,
  parameter logic [3:0]  FW_MINOR  = 4'h3,
  parameter logic [3:0]  FW_PATCH  = 4'h4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  addr_t addr_i,
  input  logic  wr_i,
  input  data_t wr_data_i,
  output data_t rd_data_o
);
  localparam addr_t ID_ADDR = addr_t'(0);
  localparam addr_t FW_ADDR = addr_t'(1);
  localparam data_t ID_WORD = data_t'(MFG_CODE);
  localparam data_t FW_WORD = {FW_BUILD, 4'h0, FW_MINOR, FW_PATCH};

  logic [N_FUNC-1:0][DATA_W-1:0] func_q;
  logic [N_PIN-1:0][DATA_W-1:0]  pen_q;
  logic [N_PIN-1:0][DATA_W-1:0]  pdir_q;
  logic [N_FUNC-1:0] func_hit;
  logic [N_PIN-1:0]  pen_hit, pdir_hit;

  for (genvar i = 0; i < N_FUNC; i++) begin : g_func
    assign func_hit[i] = (addr_i == addr_t'(FUNC_BASE + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 func_q[i] <= '0;
      else if (wr_i && func_hit[i]) func_q[i] <= wr_data_i;
    end
  end

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    assign pen_hit[i]  = (addr_i == addr_t'(PEN_BASE + i));
    assign pdir_hit[i] = (addr_i == addr_t'(PDIR_BASE + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pen_q[i]  <= '0;
        pdir_q[i] <= '0;
      end else if (wr_i) begin
        if (pen_hit[i])  pen_q[i]  <= wr_data_i;
        if (pdir_hit[i]) pdir_q[i] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ID_ADDR) rd_data_o = ID_WORD;
    if (addr_i == FW_ADDR) rd_data_o = FW_WORD;
    for (int i = 0; i < N_FUNC; i++) if (func_hit[i]) rd_data_o = func_q[i];
    for (int i = 0; i < N_PIN; i++) begin
      if (pen_hit[i])  rd_data_o = pen_q[i];
      if (pdir_hit[i]) rd_data_o = pdir_q[i];
    end
  end

  // R7 R9
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && func_hit == '0 && pen_hit == '0 && pdir_hit == '0)
      |=> $stable(func_q) && $stable(pen_q) && $stable(pdir_q));

  // R8
  func_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && func_hit[0]) |=> func_q[0] == $past(wr_data_i));

  // R8
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({func_hit, pen_hit, pdir_hit}));
endmodule

// File: rtl/bsr_slave.sv
module bsr_slave
  import bsr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         N_FUNC      = 2,
  parameter int         N_PIN       = 3,
  parameter logic [3:0] FW_BUILD    = 4'h2,
  parameter logic [3:0] FW_MINOR    = 4'h3,
  parameter logic [3:0] FW_PATCH    = 4'h4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_ni,
  input  logic stb_i,
  input  logic din_i,
  output logic dout_o
);
  logic [3:0] pins_s;
  addr_t      addr;
  logic       wr;
  data_t      wr_data, rd_data;
  logic       dout_raw;

  bsr_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, clr_ni, stb_i, din_i}),
    .q_o   (pins_s)
  );

  bsr_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pins_s[3]),
    .clr_ni   (pins_s[2]),
    .stb_i    (pins_s[1]),
    .din_i    (pins_s[0]),
    .rd_data_i(rd_data),
    .addr_o   (addr),
    .wr_o     (wr),
    .wr_data_o(wr_data),
    .dout_o   (dout_raw)
  );

  bsr_regbank #(
    .N_FUNC  (N_FUNC),
    .N_PIN   (N_PIN),
    .FW_BUILD(FW_BUILD),
    .FW_MINOR(FW_MINOR),
    .FW_PATCH(FW_PATCH)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr),
    .wr_i     (wr),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  // enable gates the line directly, without synchroniser delay
  assign dout_o = en_i & dout_raw;
endmodule

// File: tb/bsr_slave_tb_top.sv
module bsr_slave_tb_top;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, clr_n = 1'b1, stb = 1'b0, din = 1'b0;
  logic dout;
  int   n_run = 0, n_fail = 0;
  logic [15:0] model [128];

  always #5 clk = ~clk;

  bsr_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_ni(clr_n),
    .stb_i(stb), .din_i(din), .dout_o(dout)
  );

  function automatic bit is_rw(input logic [6:0] a);
    return (a == 7'h08) || (a == 7'h09) || (a >= 7'h10 && a <= 7'h12) ||
           (a >= 7'h18 && a <= 7'h1A);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [6:0] a);
    if (a == 7'h00) return 16'h0001;
    if (a == 7'h01) return 16'h2034;
    if (is_rw(a))   return model[a];
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic clear();
    clr_n = 1'b0; hold();
    clr_n = 1'b1; hold();
  endtask

  task automatic send_bit(input logic b);
    stb = 1'b0; din = b; hold();
    stb = 1'b1; hold();
  endtask

  task automatic send_cmd(input logic rd, input logic [6:0] a);
    logic [7:0] c;
    c = {rd, a};
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [15:0] v);
    clear();
    send_cmd(1'b0, a);
    for (int i = 15; i >= 0; i--) send_bit(v[i]);
    if (en && is_rw(a)) model[a] = v;
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [15:0] v);
    clear();
    send_cmd(1'b1, a);
    stb = 1'b0; hold();
    for (int i = 15; i >= 0; i--) begin
      stb = 1'b1; hold();
      stb = 1'b0; hold();
      v[i] = dout;
    end
    stb = 1'b1; hold();
  endtask

  task automatic read_chk(input string req, input logic [6:0] a);
    logic [15:0] v;
    read_reg(a, v);
    chk(req, v, exp_rd(a));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [6:0]  a;
    logic [6:0]  pick [9];
    pick = '{7'h00, 7'h01, 7'h08, 7'h09, 7'h10, 7'h12, 7'h18, 7'h1A, 7'h05};
    for (int i = 0; i < 128; i++) model[i] = 16'h0000;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hold();
    chk("R10 reset dout", {15'd0, dout}, 16'h0000);

    // R5 R6 identification words
    read_chk("R5", 7'h00);
    read_chk("R6", 7'h01);
    // R8 reset values
    read_chk("R8 reset", 7'h12);

    // R2 R3 R4 directed patterns, MSB-first both ways
    write_reg(7'h08, 16'h8001);
    read_chk("R3 R4", 7'h08);
    write_reg(7'h19, 16'hA55A);
    read_chk("R2 R8", 7'h19);

    // R7 read-only words ignore writes
    write_reg(7'h00, 16'hFFFF);
    read_chk("R7 id", 7'h00);
    write_reg(7'h01, 16'h0F0F);
    read_chk("R7 fw", 7'h01);

    // R9 unimplemented address
    write_reg(7'h7F, 16'h1234);
    read_chk("R9", 7'h7F);
    read_chk("R9 no alias", 7'h08);

    // R1 partial write aborted by clear
    clear();
    send_cmd(1'b0, 7'h09);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    read_chk("R1 abort", 7'h09);

    // R1 clear and final strobe rise in the same step: clear wins
    clear();
    send_cmd(1'b0, 7'h10);
    for (int i = 15; i >= 1; i--) send_bit(1'b1);
    stb = 1'b0; din = 1'b1; hold();
    clr_n = 1'b0; stb = 1'b1; hold();
    clr_n = 1'b1; hold();
    read_chk("R1 race", 7'h10);

    // R11 extra strobes after the frame
    write_reg(7'h11, 16'h3C3C);
    for (int i = 0; i < 20; i++) send_bit(1'b0);
    read_chk("R11", 7'h11);

    // R10 strobes ignored while disabled
    en = 1'b0; hold();
    write_reg(7'h09, 16'hFFFF);
    en = 1'b1; hold();
    read_chk("R10 ignore", 7'h09);

    // R10 dout forced low mid-read
    clear();
    send_cmd(1'b1, 7'h08);
    stb = 1'b0; hold();
    stb = 1'b1; hold();
    stb = 1'b0; hold();
    chk("R4 first bit", {15'd0, dout}, 16'h0001);
    en = 1'b0; @(negedge clk);
    chk("R10 dout low", {15'd0, dout}, 16'h0000);
    en = 1'b1; hold();
    clear();

    // random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(0, 3) == 0) a = 7'($urandom_range(0, 127));
      else                           a = pick[$urandom_range(0, 8)];
      if ($urandom_range(0, 1) == 1) write_reg(a, 16'($urandom));
      read_chk("R3 R4 R8 R9 random", a);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule